// File: doc/BRIEF.md
# Staged Left Shifter with Fill Bit

This block is a purely combinational left shifter meant to sit inside an ALU datapath. It takes a data word, an unsigned shift amount and a single fill bit. It returns the data word moved toward the most significant end by the shift amount. Every low-order position left empty by the move is loaded with the fill bit instead of zero.

The shift is built as a cascade of fixed-distance stages, one per shift-amount bit. The largest distance comes first: 16, then 8, 4, 2 and 1 for a 32-bit word. Each stage either passes its input straight through or rewires it by its own power-of-two distance. It then loads that many low bits with the fill bit. Chaining the stages fills exactly as many low bits as the total shift amount. Bits moved past the top of the word are discarded. There is no clock, no register and no flag output.

Top module: `shl_fill`

## Requirements
- R1: For every shift amount 0 to 31 and both fill values, result_o equals (data_i << shamt_i) with its low shamt_i bits set to fill_i; shamt_i is read as an unsigned binary integer.
- R2: When shamt_i is 0, result_o equals data_i bit for bit, for either value of fill_i.
- R3: For each bit position i with i >= shamt_i, result_o[i] equals data_i[i - shamt_i]; data bits moved above bit 31 do not appear anywhere in result_o.
- R4: Every bit position i with i < shamt_i of result_o equals fill_i.
- R5: When shamt_i is 31, result_o[31] equals data_i[0] and result_o[30:0] are all equal to fill_i.
- R6: With shamt_i = 4 and fill_i = 1, data 0x00000001 gives 0x0000001F. With shamt_i = 1 and fill_i = 0, data 0x00000005 gives 0x0000000A. With shamt_i = 2 and fill_i = 0, data 34 gives 136.
- R7: Bit k of shamt_i alone (all other bits 0) moves the word by exactly 2^k positions, with k = 4 giving 16, k = 3 giving 8, and so on down to k = 0 giving 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | DATA_W (32) | Word to be shifted |
| shamt_i | input | $clog2(DATA_W) (5) | Unsigned shift amount |
| fill_i | input | 1 | Value loaded into vacated low bits |
| result_o | output | DATA_W (32) | Shifted word with fill |

## Verification
The bench builds the block with its default DATA_W of 32, so the 5-bit shift amount covers only 32 values. That small range lets every amount be swept with both fill values on each corner data word: zero, one, all ones, the top bit alone and an alternating pattern. Single-bit shift amounts isolate each cascade stage. Seeded random words and amounts then cover combinations of stages that the directed cases do not reach.

// File: rtl/shl_fill_pkg.sv
package shl_fill_pkg;

  // Distance of cascade stage idx (0 = first) for a shift field of amt_w bits.
  function automatic int stage_dist(input int idx, input int amt_w);
    return 1 << (amt_w - 1 - idx);
  endfunction

  // Bit of the shift amount that selects stage idx.
  function automatic int stage_sel_bit(input int idx, input int amt_w);
    return amt_w - 1 - idx;
  endfunction

endpackage

// File: rtl/shl_fill_stage.sv
module shl_fill_stage #(
  parameter int DATA_W = 32,
  parameter int DIST   = 16
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic              en_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] dout_o
);

  logic [DATA_W-1:0] moved;

  // Pure rewiring: upper bits take lower input bits, low DIST bits take fill.
  assign moved  = {din_i[DATA_W-1-DIST:0], {DIST{fill_i}}};
  assign dout_o = en_i ? moved : din_i;

endmodule

// File: rtl/shl_fill_cascade.sv
module shl_fill_cascade
  import shl_fill_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               fill_i,
  output logic [DATA_W-1:0]  result_o
);

  logic [DATA_W-1:0] link [SHAMT_W+1];

  assign link[0] = data_i;

  for (genvar g = 0; g < SHAMT_W; g++) begin : g_stage
    localparam int Dist = stage_dist(g, SHAMT_W);
    localparam int Sel  = stage_sel_bit(g, SHAMT_W);
    shl_fill_stage #(
      .DATA_W (DATA_W),
      .DIST   (Dist)
    ) stage_i (
      .din_i  (link[g]),
      .en_i   (shamt_i[Sel]),
      .fill_i (fill_i),
      .dout_o (link[g+1])
    );
  end

  assign result_o = link[SHAMT_W];

endmodule

// File: rtl/shl_fill.sv
module shl_fill #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               fill_i,
  output logic [DATA_W-1:0]  result_o
);

  // Full coverage of shift amounts needs a power-of-two width.
  initial begin
    if ((1 << SHAMT_W) != DATA_W)
      $error("shl_fill: DATA_W must be a power of two");
  end

  shl_fill_cascade #(
    .DATA_W  (DATA_W),
    .SHAMT_W (SHAMT_W)
  ) cascade_i (
    .data_i   (data_i),
    .shamt_i  (shamt_i),
    .fill_i   (fill_i),
    .result_o (result_o)
  );

endmodule

// File: rtl/shl_fill_chk.sv
module shl_fill_chk #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0]  data_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic               fill_i,
  input logic [DATA_W-1:0]  result_o
);

  logic [DATA_W-1:0] low_mask;
  logic [DATA_W-1:0] keep_mask;

  assign low_mask  = ~({DATA_W{1'b1}} << shamt_i);
  assign keep_mask = {DATA_W{1'b1}} >> shamt_i;

  always_comb begin
    // R2
    if (shamt_i == '0)
      a_r2_zero_pass: assert (result_o == data_i)
        else $error("a_r2_zero_pass");
    // R3: undoing the move recovers the data bits that stayed in range
    a_r3_data_kept: assert ((result_o >> shamt_i) == (data_i & keep_mask))
      else $error("a_r3_data_kept");
    // R4
    a_r4_low_fill: assert ((result_o & low_mask) == (fill_i ? low_mask : '0))
      else $error("a_r4_low_fill");
    // R5
    if (shamt_i == SHAMT_W'(DATA_W - 1))
      a_r5_max_shift: assert (result_o[DATA_W-1] == data_i[0] &&
                              $countones(result_o[DATA_W-2:0]) ==
                              (fill_i ? DATA_W - 1 : 0))
        else $error("a_r5_max_shift");
  end

endmodule

bind shl_fill shl_fill_chk #(
  .DATA_W  (DATA_W),
  .SHAMT_W (SHAMT_W)
) chk_i (
  .data_i   (data_i),
  .shamt_i  (shamt_i),
  .fill_i   (fill_i),
  .result_o (result_o)
);

// File: tb/shl_fill_tb_top.sv
module shl_fill_tb_top;

  localparam int DataW  = 32;
  localparam int ShamtW = 5;

  logic              clk;
  logic              rst_ni;
  logic [DataW-1:0]  data;
  logic [ShamtW-1:0] shamt;
  logic              fill;
  logic [DataW-1:0]  result;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  shl_fill #(.DATA_W(DataW), .SHAMT_W(ShamtW)) dut_i (
    .data_i   (data),
    .shamt_i  (shamt),
    .fill_i   (fill),
    .result_o (result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] ref_shl(input logic [31:0] d, input int s, input logic f);
    logic [63:0] m;
    m = (64'd1 << s) - 64'd1;
    return (d << s) | (f ? m[31:0] : 32'd0);
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    n_cmp++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s data=%h shamt=%0d fill=%0b actual=%h expected=%h",
               req, data, shamt, fill, result, exp);
    end
  endtask

  // Drive on the rising edge, compare on the falling edge.
  task automatic apply(input logic [31:0] d, input int s, input logic f, input string req);
    @(posedge clk);
    data  = d;
    shamt = ShamtW'(s);
    fill  = f;
    @(negedge clk);
    check(req, ref_shl(d, s, f));
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] corners [5];
    corners[0] = 32'h0000_0000;
    corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF;
    corners[3] = 32'h8000_0000;
    corners[4] = 32'hA5A5_5A5A;

    data = '0; shamt = '0; fill = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 idle", 32'h0);

    // R6 worked examples
    apply(32'h1, 4, 1'b1, "R6 one<<4 fill1");
    check("R6 0x1F", 32'h0000_001F);
    apply(32'h5, 1, 1'b0, "R6 five<<1");
    check("R6 0x0A", 32'h0000_000A);
    apply(32'd34, 2, 1'b0, "R6 34<<2");
    check("R6 136", 32'd136);

    // R2 zero shift, both fills
    apply(32'h1234_5678, 0, 1'b1, "R2 zero fill1");
    check("R2 passthrough", 32'h1234_5678);
    apply(32'h1234_5678, 0, 1'b0, "R2 zero fill0");

    // R5 maximum shift
    apply(32'h0000_0001, 31, 1'b0, "R5 max");
    check("R5 max fill0", 32'h8000_0000);
    apply(32'hFFFF_FFFE, 31, 1'b1, "R5 max");
    check("R5 max fill1", 32'h7FFF_FFFF);

    // R7 each stage alone
    for (int k = 0; k < ShamtW; k++) begin
      apply(32'h0000_0001, 1 << k, 1'b0, "R7 stage");
      check("R7 stage dist", 32'h1 << (1 << k));
    end

    // R1/R3/R4 sweep of every amount, both fills, corner words
    for (int c = 0; c < 5; c++)
      for (int s = 0; s < 32; s++)
        for (int f = 0; f < 2; f++)
          apply(corners[c], s, f[0], "R1 R3 R4 sweep");

    // R1 seeded random
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 3000; i++)
      apply($urandom, $urandom % 32, $urandom % 2 == 1, "R1 random");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule